// File: doc/BRIEF.md
# Horizontal Blanking Clock Mask Generator

This block holds a horizontal shift clock at a fixed level for the length of a blanking window and lets the clock through unchanged the rest of the time. The window comes from one of two sources. The first is an internal generator that counts pixel clocks from the start of each line and inverts its output at up to six programmed pixel positions. The second is an external blanking input of selectable polarity. Each source has its own forced level. The internal source has one level for each of its four sequences, and the external source has a single level.

Lines are counted inside a field. The line count decides which of four regions is in force, and a pointer byte maps each region to one of four toggle sequences. Region 0 starts at line 0, and the other three regions start at programmable line boundaries. All settings are written through a simple synchronous write port. The pixel clock is the block clock. The line and field strobes are synchronous to it, and so is the external blanking input.

Top module: `hblank_clk_mask`

## Requirements
- R1: After reset, int_blank is 0 and shift_clk_out follows shift_clk_in.
- R2: A line start is a cycle with line_strobe or field_strobe high. In the cycle after it, the pixel count is 0 and int_blank is 0.
- R3: Toggle k (0..5) of sequence s is held at address 8+3s+k/2, in wr_data bits [11:0] for even k and bits [23:12] for odd k. During the cycle whose pixel count is p, int_blank equals the parity of the number of toggles already taken at a pixel count below p. A toggle is taken when the pixel count equals it. The toggles are taken in index order, and a toggle whose value is not above the one taken before it is never reached, so neither it nor any toggle after it takes effect.
- R4: A toggle value of 0xFFF disables that toggle and every toggle after it in the sequence.
- R5: The mode word at address 0 holds four internal mask levels in bits [6:3], one per sequence, with sequence s at bit 3+s. A level bit of 0 forces the clock low and 1 forces it high. While internal blanking is in use, shift_clk_out takes the level of the current sequence in the cycle after int_blank is 1.
- R6: Mode bit 0 set to 1 selects the external source. Mode bit 1 gives the polarity of ext_blank_in: 0 means active low and 1 means active high. Mode bit 2 gives the forced level. When ext_blank_in is active in one cycle, shift_clk_out holds that forced level in the next cycle.
- R7: A field strobe sets the line count to 0, and each line strobe without a field strobe adds 1, saturating at 0xFFF. Region r (1..3) starts at the 12-bit boundary written at address 1+r. The active region is the highest one whose boundary is no greater than the line count, with region 0 as the fallback. Bits [2r+1:2r] of the pointer byte at address 1 give the sequence for region r.
- R8: While the selected source is not blanking, shift_clk_out equals shift_clk_in with no clock delay. A change into or out of the forced level happens only at a pixel clock edge.
- R9: At reset the mode word is 0x7C, the pointer byte is 0, every boundary is 0xFFF and every toggle word is 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | 1 | Start of line, one cycle |
| field_strobe | input | 1 | Start of field, one cycle; also starts a line |
| ext_blank_in | input | 1 | External blanking input |
| shift_clk_in | input | 1 | Free-running shift clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 24 | Register write data |
| shift_clk_out | output | 1 | Masked shift clock |
| int_blank | output | 1 | Internal blanking window |

## Verification
The bench goes after toggle lists that stop early. One case is a 0xFFF in the middle of a list: a design that skipped over it would let later toggles reopen the window. Another is a list that falls back out of order or repeats a value: a design that searched every toggle instead of stepping through them in order would close the window where it should stay open. Region boundaries are placed a few lines apart, each region mapped to its own sequence and mask level, so picking the wrong region or the wrong pointer field shows up as the wrong window or the wrong forced level. The external source is exercised with both polarities and both levels. A reversed polarity would mask in the gaps instead of the windows, and a missing register stage would move every edge by one pixel.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  parameter int POS_W  = 12;
  parameter int NSEQ   = 4;
  parameter int NTOG   = 6;
  parameter int NREG   = 4;
  parameter int ADDR_W = 5;
  localparam int DATA_W = 2 * POS_W;
  localparam int SEL_W  = $clog2(NSEQ);
  localparam int RIDX_W = $clog2(NREG);
  localparam int TIDX_W = $clog2(NTOG + 1);
  localparam int NWORD  = NSEQ * NTOG / 2;
  localparam int ADDR_MODE = 0;
  localparam int ADDR_PTR  = 1;
  localparam int ADDR_TOG  = 8;

  typedef logic [POS_W-1:0] pos_t;
  localparam pos_t POS_OFF = '1;

  typedef struct packed {
    logic [NSEQ-1:0] int_lvl;
    logic            ext_lvl;
    logic            ext_pol;
    logic            src_ext;
  } mode_t;
endpackage

// File: rtl/hbm_regs.sv
module hbm_regs
  import hbm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output mode_t                    mode,
  output logic [SEL_W*NREG-1:0]    ptr,
  output pos_t [NREG-1:0]          bnd,
  output pos_t [NSEQ*NTOG-1:0]     tog
);
  localparam mode_t MODE_RST = '{int_lvl: '1, ext_lvl: 1'b1, ext_pol: 1'b0, src_ext: 1'b0};

  mode_t                 mode_q, mode_d;
  logic [SEL_W*NREG-1:0] ptr_q, ptr_d;
  logic                  mode_we, ptr_we;

  assign mode_we = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));
  assign ptr_we  = wr_en && (wr_addr == ADDR_W'(ADDR_PTR));

  always_comb begin
    mode_d = mode_q;
    ptr_d  = ptr_q;
    if (mode_we) mode_d = mode_t'(wr_data[$bits(mode_t)-1:0]);
    if (ptr_we)  ptr_d  = wr_data[SEL_W*NREG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      ptr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      ptr_q  <= ptr_d;
    end
  end

  assign mode   = mode_q;
  assign ptr    = ptr_q;
  assign bnd[0] = '0;

  for (genvar r = 1; r < NREG; r++) begin : g_bnd
    pos_t bnd_q;
    logic bnd_we;
    assign bnd_we = wr_en && (wr_addr == ADDR_W'(ADDR_PTR + r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bnd_q <= POS_OFF;
      else if (bnd_we) bnd_q <= wr_data[POS_W-1:0];
    end
    assign bnd[r] = bnd_q;
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              word_we;
    assign word_we = wr_en && (wr_addr == ADDR_W'(ADDR_TOG + w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '1;
      else if (word_we) word_q <= wr_data;
    end
    assign tog[2*w]   = word_q[POS_W-1:0];
    assign tog[2*w+1] = word_q[DATA_W-1:POS_W];
  end
endmodule

// File: rtl/hbm_timing.sv
module hbm_timing
  import hbm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_strobe,
  input  logic                  field_strobe,
  input  logic [SEL_W*NREG-1:0] ptr,
  input  pos_t [NREG-1:0]       bnd,
  output pos_t                  pix,
  output pos_t                  line_cnt,
  output logic [SEL_W-1:0]      seq
);
  pos_t              pix_q, pix_d, line_q, line_d;
  logic [RIDX_W-1:0] reg_idx;

  always_comb begin
    if (line_strobe || field_strobe) pix_d = '0;
    else if (pix_q == POS_OFF)       pix_d = pix_q;
    else                             pix_d = pix_q + POS_W'(1);

    if (field_strobe)                          line_d = '0;
    else if (line_strobe && line_q != POS_OFF) line_d = line_q + POS_W'(1);
    else                                       line_d = line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      pix_q  <= pix_d;
      line_q <= line_d;
    end
  end

  always_comb begin
    reg_idx = '0;
    for (int r = 1; r < NREG; r++)
      if (line_q >= bnd[r]) reg_idx = RIDX_W'(r);
  end

  assign seq      = ptr[SEL_W*reg_idx +: SEL_W];
  assign pix      = pix_q;
  assign line_cnt = line_q;
endmodule

// File: rtl/hbm_toggle.sv
module hbm_toggle
  import hbm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  pos_t                 pix,
  input  logic [SEL_W-1:0]     seq,
  input  pos_t [NSEQ*NTOG-1:0] tog,
  output pos_t                 cur_tog,
  output logic                 blank
);
  logic [TIDX_W-1:0] tidx_q, tidx_d;
  logic              blank_q, blank_d;
  logic              hit;

  always_comb begin
    cur_tog = POS_OFF;
    for (int k = 0; k < NTOG; k++)
      if (tidx_q == TIDX_W'(k)) cur_tog = tog[int'(seq)*NTOG + k];
  end

  assign hit = (cur_tog != POS_OFF) && (pix == cur_tog);

  always_comb begin
    tidx_d  = tidx_q;
    blank_d = blank_q;
    if (start) begin
      tidx_d  = '0;
      blank_d = 1'b0;
    end else if (hit) begin
      tidx_d  = tidx_q + TIDX_W'(1);
      blank_d = ~blank_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tidx_q  <= '0;
      blank_q <= 1'b0;
    end else begin
      tidx_q  <= tidx_d;
      blank_q <= blank_d;
    end
  end

  assign blank = blank_q;
endmodule

// File: rtl/hblank_clk_mask.sv
module hblank_clk_mask
  import hbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe,
  input  logic              field_strobe,
  input  logic              ext_blank_in,
  input  logic              shift_clk_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              shift_clk_out,
  output logic              int_blank
);
  logic [1:0]            rs_q;
  logic                  rst_n_s;
  mode_t                 mode_w;
  logic [SEL_W*NREG-1:0] ptr_w;
  pos_t [NREG-1:0]       bnd_w;
  pos_t [NSEQ*NTOG-1:0]  tog_w;
  pos_t                  pix_w, line_w, cur_tog;
  logic [SEL_W-1:0]      seq_w;
  logic                  blank_w, ext_act;
  logic                  mask_q, mask_d, lvl_q, lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  hbm_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode_w), .ptr(ptr_w), .bnd(bnd_w), .tog(tog_w)
  );

  hbm_timing u_timing (
    .clk(clk), .rst_n(rst_n_s), .line_strobe(line_strobe), .field_strobe(field_strobe),
    .ptr(ptr_w), .bnd(bnd_w), .pix(pix_w), .line_cnt(line_w), .seq(seq_w)
  );

  hbm_toggle u_toggle (
    .clk(clk), .rst_n(rst_n_s), .start(line_strobe | field_strobe), .pix(pix_w),
    .seq(seq_w), .tog(tog_w), .cur_tog(cur_tog), .blank(blank_w)
  );

  assign ext_act = mode_w.ext_pol ? ext_blank_in : ~ext_blank_in;

  always_comb begin
    if (mode_w.src_ext) begin
      mask_d = ext_act;
      lvl_d  = mode_w.ext_lvl;
    end else begin
      mask_d = blank_w;
      lvl_d  = mode_w.int_lvl[seq_w];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mask_q <= 1'b0;
      lvl_q  <= 1'b1;
    end else begin
      mask_q <= mask_d;
      lvl_q  <= lvl_d;
    end
  end

  assign shift_clk_out = mask_q ? lvl_q : shift_clk_in;
  assign int_blank     = blank_w;
endmodule

// File: rtl/hbm_checker.sv
module hbm_checker
  import hbm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             line_strobe,
  input logic             field_strobe,
  input logic             ext_blank_in,
  input logic             shift_clk_in,
  input logic             shift_clk_out,
  input logic             int_blank,
  input logic             wr_en,
  input mode_t            mode,
  input logic [SEL_W-1:0] seq,
  input pos_t             cur_tog,
  input pos_t             pix,
  input pos_t             line_cnt
);
  p_line_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe || field_strobe) |=> !int_blank);

  p_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_strobe && !field_strobe && cur_tog == POS_OFF) |=> $stable(int_blank));

  p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.src_ext && int_blank && !wr_en) |=> (shift_clk_out == $past(mode.int_lvl[seq])));

  p_ext_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.src_ext && mode.ext_pol && ext_blank_in && mode.ext_lvl && !wr_en) |=> shift_clk_out);

  p_field_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    field_strobe |=> (line_cnt == '0 && pix == '0));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.src_ext && !int_blank && !wr_en) |=> (shift_clk_out == shift_clk_in));
endmodule

bind hblank_clk_mask hbm_checker u_chk (
  .clk(clk), .rst_n(rst_n_s), .line_strobe(line_strobe), .field_strobe(field_strobe),
  .ext_blank_in(ext_blank_in), .shift_clk_in(shift_clk_in), .shift_clk_out(shift_clk_out),
  .int_blank(int_blank), .wr_en(wr_en), .mode(mode_w), .seq(seq_w), .cur_tog(cur_tog),
  .pix(pix_w), .line_cnt(line_w)
);

// File: tb/hblank_clk_mask_tb.sv
module hblank_clk_mask_tb;
  logic        clk = 1'b0;
  logic        rst_n, line_strobe, field_strobe, ext_blank_in, shift_clk_in, wr_en;
  logic [4:0]  wr_addr;
  logic [23:0] wr_data;
  logic        shift_clk_out, int_blank;

  int errors = 0;
  int checks = 0;

  logic [11:0] t_m [4][6];
  logic [3:0]  lvl_m;
  logic        src_m, pol_m, elvl_m;
  logic [7:0]  ptr_m;
  logic [11:0] bnd_m [4];
  int          line_m;

  hblank_clk_mask u_dut (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .field_strobe(field_strobe),
    .ext_blank_in(ext_blank_in), .shift_clk_in(shift_clk_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .shift_clk_out(shift_clk_out), .int_blank(int_blank)
  );

  always #5 clk = ~clk;

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_ib(int s, int p);
    int prev = -1;
    int cnt = 0;
    for (int k = 0; k < 6; k++) begin
      if (t_m[s][k] == 12'hFFF) break;
      if (int'(t_m[s][k]) <= prev) break;
      prev = int'(t_m[s][k]);
      if (prev < p) cnt++;
    end
    return cnt[0];
  endfunction

  function automatic int seq_of(int ln);
    int r = 0;
    for (int k = 1; k < 4; k++) if (ln >= int'(bnd_m[k])) r = k;
    return int'(ptr_m[2*r +: 2]);
  endfunction

  task automatic wr(input int a, input logic [23:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_seq(input int s);
    for (int w = 0; w < 3; w++) wr(8 + 3*s + w, {t_m[s][2*w+1], t_m[s][2*w]});
  endtask

  task automatic push_mode();
    wr(0, {17'd0, lvl_m, elvl_m, pol_m, src_m});
  endtask

  task automatic run_line(input int len, input bit fld, input string tag);
    int s;
    bit m;
    line_strobe = 1'b1; field_strobe = fld;
    @(negedge clk);
    line_m = fld ? 0 : ((line_m < 4095) ? line_m + 1 : 4095);
    s = seq_of(line_m);
    line_strobe = 1'b0; field_strobe = 1'b0;
    for (int p = 0; p < len; p++) begin
      shift_clk_in = 1'($urandom);
      #1;
      chk(int_blank == exp_ib(s, p), (p == 0) ? "R2" : tag, int_blank, exp_ib(s, p));
      if (p >= 1) begin
        m = exp_ib(s, p - 1);
        chk(shift_clk_out == (m ? lvl_m[s] : shift_clk_in), m ? "R5" : "R8",
            shift_clk_out, m ? lvl_m[s] : shift_clk_in);
      end
      @(negedge clk);
    end
  endtask

  task automatic rand_seq(input int s);
    int prev = $urandom % 8;
    bit wild = ($urandom % 6) == 0;
    for (int k = 0; k < 6; k++) begin
      t_m[s][k] = wild ? 12'($urandom % 70) : 12'(prev);
      prev = prev + 1 + ($urandom % 12);
      if (($urandom % 10) == 0) t_m[s][k] = 12'hFFF;
    end
  endtask

  initial begin
    bit pa;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; line_strobe = 1'b0; field_strobe = 1'b0; ext_blank_in = 1'b0;
    shift_clk_in = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    for (int s = 0; s < 4; s++) for (int k = 0; k < 6; k++) t_m[s][k] = 12'hFFF;
    lvl_m = 4'hF; src_m = 0; pol_m = 0; elvl_m = 1; ptr_m = 8'h00;
    for (int r = 0; r < 4; r++) bnd_m[r] = (r == 0) ? 12'h000 : 12'hFFF;
    line_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      shift_clk_in = 1'($urandom);
      #1;
      chk(int_blank == 1'b0, "R1", int_blank, 0);
      chk(shift_clk_out == shift_clk_in, "R1", shift_clk_out, shift_clk_in);
      @(negedge clk);
    end
    // R9: default toggles are all disabled, default levels high
    run_line(40, 1'b1, "R9");

    // R3: six ascending toggles on sequence 0
    t_m[0] = '{12'd5, 12'd9, 12'd20, 12'd30, 12'd40, 12'd50};
    push_seq(0);
    run_line(60, 1'b1, "R3");
    run_line(60, 1'b0, "R3");

    // R4: a disabled toggle stops the rest
    t_m[0] = '{12'd5, 12'd9, 12'hFFF, 12'd30, 12'd40, 12'd50};
    push_seq(0);
    run_line(60, 1'b0, "R4");
    t_m[0] = '{12'd7, 12'hFFF, 12'd20, 12'd30, 12'd40, 12'd50};
    push_seq(0);
    run_line(60, 1'b0, "R4");

    // R3: out-of-order list stops at the first step back
    t_m[0] = '{12'd10, 12'd4, 12'd20, 12'd30, 12'hFFF, 12'hFFF};
    push_seq(0);
    run_line(40, 1'b0, "R3");
    run_line(40, 1'b0, "R2");

    // R5: internal mask level low
    lvl_m = 4'b1110; push_mode();
    t_m[0] = '{12'd3, 12'd12, 12'd15, 12'd25, 12'hFFF, 12'hFFF};
    push_seq(0);
    run_line(40, 1'b0, "R5");

    // R7: regions map to distinct sequences
    bnd_m[1] = 12'd2; bnd_m[2] = 12'd4; bnd_m[3] = 12'd6;
    for (int r = 1; r < 4; r++) wr(1 + r, {12'd0, bnd_m[r]});
    ptr_m = 8'hE4; wr(1, {16'd0, ptr_m});
    lvl_m = 4'b0101; push_mode();
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 6; k++) t_m[s][k] = 12'hFFF;
      t_m[s][0] = 12'(2 + 5*s);
      t_m[s][1] = 12'(8 + 7*s);
    end
    for (int s = 0; s < 4; s++) push_seq(s);
    run_line(50, 1'b1, "R7");
    for (int l = 0; l < 8; l++) run_line(50, 1'b0, "R7");
    ptr_m = 8'h1B; wr(1, {16'd0, ptr_m});
    run_line(50, 1'b1, "R7");
    for (int l = 0; l < 7; l++) run_line(50, 1'b0, "R7");

    // random mix
    for (int it = 0; it < 20; it++) begin
      for (int s = 0; s < 4; s++) begin rand_seq(s); push_seq(s); end
      ptr_m = 8'($urandom); wr(1, {16'd0, ptr_m});
      for (int r = 1; r < 4; r++) begin
        bnd_m[r] = 12'(1 + $urandom % 6); wr(1 + r, {12'd0, bnd_m[r]});
      end
      lvl_m = 4'($urandom); push_mode();
      run_line(90, 1'b1, "R3");
      for (int l = 0; l < 6; l++) run_line(90, 1'b0, "R7");
    end

    // R6: external source, all polarity and level combinations
    for (int c = 0; c < 4; c++) begin
      src_m = 1; pol_m = c[0]; elvl_m = c[1]; push_mode();
      pa = 1'b0;
      for (int i = 0; i < 60; i++) begin
        ext_blank_in = 1'($urandom); shift_clk_in = 1'($urandom);
        #1;
        if (i > 0) chk(shift_clk_out == (pa ? elvl_m : shift_clk_in), "R6",
                       shift_clk_out, pa ? elvl_m : shift_clk_in);
        pa = pol_m ? ext_blank_in : ~ext_blank_in;
        @(negedge clk);
      end
    end
    src_m = 0; pol_m = 0; elvl_m = 1; ext_blank_in = 1'b0; push_mode();
    run_line(90, 1'b1, "R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule